// File: doc/BRIEF.md
# Six-Mode Programmable Counter Channel

This block is a single 16-bit timer channel that counts down on a qualifying clock enable and drives one output waveform whose shape depends on the selected mode. The host loads an initial value and a 3-bit mode together with one strobe. A gate input can pause counting or restart it, depending on the mode. The live count is always visible on a port, so that a separate bus interface block can latch it and return it to software.

Six behaviours are offered:
- a terminal-count flag that stays high once reached;
- a gate-retriggerable one-shot;
- a rate generator that gives a one-count pulse each period;
- a square wave whose readable count falls by two per tick;
- a software strobe;
- a gate-triggered strobe.

A loaded value of zero stands for a full period of 65536 counts. Mode codes 6 and 7 are aliases of codes 2 and 3.

Time inside the channel is kept as the number of enabled ticks since the last load or restart. In the periodic modes this is a phase that wraps at the period. In the other modes it saturates just past the terminal count, and a separate 16-bit tally supplies the wrapping readback.

Top module: `icc_counter_channel`

## Requirements
- R1: A loaded value of 0 acts as a terminal count of 65536. The readback after loading is 0, and the first tick makes it 16'hFFFF.
- R2: A load strobe captures the value and the mode code together. In the next cycle the count port reads the loaded value and the elapsed count is zero, whatever the previous state.
- R3: The elapsed count advances only in cycles where cnt_en is high. With cnt_en low, no load and no retrigger, the count and the output hold.
- R4: Mode code 0 drives the output high once the elapsed count reaches the initial count, and it stays high. The count reads the initial value minus elapsed ticks, modulo 2^16.
- R5: Mode code 1 drives the output high while the elapsed count is below the initial count, and low after that. The count wraps as in R4.
- R6: Mode code 2 drives the output high for exactly the counts at which the elapsed count is a nonzero multiple of the initial count N. While it is high, the count reads N modulo 2^16. The count reads N minus the phase.
- R7: Mode code 3 gives a square wave that is high for the first (N+1)/2 counts of each period. The count reads N minus twice the phase, reduced modulo N.
- R8: Mode codes 4 and 5 drive the output high only while the elapsed count equals the initial count. The count then reads 0.
- R9: A rising gate edge in mode codes 1, 2, 3 and 5 restarts counting from the initial value. In mode codes 0 and 4 it has no effect on the count.
- R10: A low gate pauses counting in mode codes 0, 2, 3 and 4. It does not pause mode codes 1 and 5.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: After reset the channel is in the square-wave mode with a period of 65536. The count reads 0 and the output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_en | input | 1 | Counter clock enable; one tick per high cycle |
| load_strobe | input | 1 | Captures load_value and mode_sel and restarts the count |
| load_value | input | 16 | Initial count; 0 means 65536 |
| mode_sel | input | 3 | Output mode code, sampled on load_strobe |
| gate | input | 1 | Gate level; pauses or retriggers according to mode |
| out_wave | output | 1 | Mode-dependent output waveform |
| count_now | output | 16 | Live readable count |

## Verification
The assertions check the following relations on every cycle:
- the readback equals the loaded value one cycle after a load;
- count and output hold with no tick;
- count holds under a low gate in the pausing modes;
- the terminal-count flag stays high once set;
- a retrigger reloads the count;
- a strobe or rate pulse coincides with the count value it implies.

Only the directed scenarios can show the following:
- the waveform timing itself (when the flag rises, the square-wave duty split, the wrap of the readback past zero, the strobe lasting one count);
- the 65536-count periods;
- the mode 6 and 7 aliases.

// File: rtl/icc_pkg.sv
package icc_pkg;

  typedef enum logic [2:0] {
    MD_TERM     = 3'd0,
    MD_ONESHOT  = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } icc_mode_e;

  // Codes 6 and 7 fold onto the rate and square modes.
  function automatic icc_mode_e canon_mode(input logic [2:0] code);
    case (code)
      3'd0: canon_mode = MD_TERM;
      3'd1: canon_mode = MD_ONESHOT;
      3'd2, 3'd6: canon_mode = MD_RATE;
      3'd4: canon_mode = MD_SWSTROBE;
      3'd5: canon_mode = MD_HWSTROBE;
      default: canon_mode = MD_SQUARE;
    endcase
  endfunction

  function automatic logic gate_pauses(input icc_mode_e m);
    gate_pauses = (m == MD_TERM) || (m == MD_RATE) ||
                  (m == MD_SQUARE) || (m == MD_SWSTROBE);
  endfunction

  function automatic logic gate_retrigs(input icc_mode_e m);
    gate_retrigs = (m == MD_ONESHOT) || (m == MD_RATE) ||
                   (m == MD_SQUARE) || (m == MD_HWSTROBE);
  endfunction

  function automatic logic is_periodic(input icc_mode_e m);
    is_periodic = (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

endpackage

// File: rtl/icc_rst_sync.sv
module icc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/icc_mode_reg.sv
module icc_mode_reg
  import icc_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int TERM_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_strobe,
  input  logic [CNT_W-1:0]  load_value,
  input  logic [2:0]        mode_sel,
  output icc_mode_e         mode_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic [TERM_W-1:0] term,
  output logic [TERM_W-1:0] half,
  output logic              pause_en,
  output logic              retrig_en,
  output logic              periodic
);
  icc_mode_e        mode_d;
  logic [CNT_W-1:0] reload_d;

  always_comb begin
    mode_d   = mode_q;
    reload_d = reload_q;
    if (load_strobe) begin
      mode_d   = canon_mode(mode_sel);
      reload_d = load_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_SQUARE;
      reload_q <= '0;
    end else begin
      mode_q   <= mode_d;
      reload_q <= reload_d;
    end
  end

  // Zero stands for the full 2^CNT_W period.
  assign term      = (reload_q == '0) ? (TERM_W'(1) << CNT_W) : {1'b0, reload_q};
  assign half      = (term + TERM_W'(1)) >> 1;
  assign pause_en  = gate_pauses(mode_q);
  assign retrig_en = gate_retrigs(mode_q);
  assign periodic  = is_periodic(mode_q);
endmodule

// File: rtl/icc_gate_edge.sv
module icc_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/icc_elapsed.sv
module icc_elapsed #(
  parameter int CNT_W  = 16,
  localparam int TERM_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              gate,
  input  logic              gate_rise,
  input  logic              load_strobe,
  input  logic              pause_en,
  input  logic              retrig_en,
  input  logic              periodic,
  input  logic [TERM_W-1:0] term,
  output logic [TERM_W-1:0] elap_q,
  output logic [CNT_W-1:0]  wrap_q,
  output logic              started_q
);
  logic [TERM_W-1:0] elap_d;
  logic [CNT_W-1:0]  wrap_d;
  logic              started_d;
  logic              restart;
  logic              tick;

  assign restart = load_strobe | (retrig_en & gate_rise);
  assign tick    = cnt_en & (gate | ~pause_en);

  always_comb begin
    elap_d    = elap_q;
    wrap_d    = wrap_q;
    started_d = started_q;
    if (restart) begin
      elap_d    = '0;
      wrap_d    = '0;
      started_d = 1'b0;
    end else if (tick) begin
      started_d = 1'b1;
      wrap_d    = wrap_q + CNT_W'(1);
      if (periodic) begin
        // Phase within the period.
        elap_d = (elap_q >= term - TERM_W'(1)) ? '0 : elap_q + TERM_W'(1);
      end else begin
        // Saturate one past the terminal count.
        elap_d = (elap_q > term) ? elap_q : elap_q + TERM_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elap_q    <= '0;
      wrap_q    <= '0;
      started_q <= 1'b0;
    end else begin
      elap_q    <= elap_d;
      wrap_q    <= wrap_d;
      started_q <= started_d;
    end
  end
endmodule

// File: rtl/icc_wave.sv
module icc_wave
  import icc_pkg::*;
#(
  parameter int CNT_W  = 16,
  localparam int TERM_W = CNT_W + 1
) (
  input  icc_mode_e         mode_q,
  input  logic [TERM_W-1:0] term,
  input  logic [TERM_W-1:0] half,
  input  logic [TERM_W-1:0] elap_q,
  input  logic [CNT_W-1:0]  wrap_q,
  input  logic              started_q,
  output logic              out_wave,
  output logic [CNT_W-1:0]  count_now
);
  logic [TERM_W:0]   dbl;
  logic [TERM_W:0]   dbl_red;
  logic [TERM_W-1:0] rate_cnt;
  logic [TERM_W:0]   sq_cnt;

  always_comb begin
    dbl      = {elap_q, 1'b0};
    dbl_red  = (dbl >= {1'b0, term}) ? dbl - {1'b0, term} : dbl;
    rate_cnt = term - elap_q;
    sq_cnt   = {1'b0, term} - dbl_red;
    out_wave  = 1'b0;
    count_now = term[CNT_W-1:0] - wrap_q;
    case (mode_q)
      MD_TERM:    out_wave = (elap_q >= term);
      MD_ONESHOT: out_wave = (elap_q < term);
      MD_RATE: begin
        out_wave  = started_q && (elap_q == '0);
        count_now = rate_cnt[CNT_W-1:0];
      end
      MD_SQUARE: begin
        out_wave  = (elap_q < half);
        count_now = sq_cnt[CNT_W-1:0];
      end
      default:    out_wave = (elap_q == term);
    endcase
  end
endmodule

// File: rtl/icc_counter_channel.sv
module icc_counter_channel
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             load_strobe,
  input  logic [CNT_W-1:0] load_value,
  input  logic [2:0]       mode_sel,
  input  logic             gate,
  output logic             out_wave,
  output logic [CNT_W-1:0] count_now
);
  localparam int TERM_W = CNT_W + 1;

  logic              rst_sync_n;
  icc_mode_e         mode_q;
  logic [CNT_W-1:0]  reload_q;
  logic [TERM_W-1:0] term;
  logic [TERM_W-1:0] half;
  logic              pause_en;
  logic              retrig_en;
  logic              periodic;
  logic              gate_rise;
  logic [TERM_W-1:0] elap_q;
  logic [CNT_W-1:0]  wrap_q;
  logic              started_q;

  icc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  icc_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .load_strobe(load_strobe),
    .load_value(load_value), .mode_sel(mode_sel), .mode_q(mode_q),
    .reload_q(reload_q), .term(term), .half(half), .pause_en(pause_en),
    .retrig_en(retrig_en), .periodic(periodic)
  );

  icc_gate_edge u_gate (
    .clk(clk), .rst_n(rst_sync_n), .gate(gate), .gate_rise(gate_rise)
  );

  icc_elapsed #(.CNT_W(CNT_W)) u_elap (
    .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .gate(gate),
    .gate_rise(gate_rise), .load_strobe(load_strobe), .pause_en(pause_en),
    .retrig_en(retrig_en), .periodic(periodic), .term(term),
    .elap_q(elap_q), .wrap_q(wrap_q), .started_q(started_q)
  );

  icc_wave #(.CNT_W(CNT_W)) u_wave (
    .mode_q(mode_q), .term(term), .half(half), .elap_q(elap_q),
    .wrap_q(wrap_q), .started_q(started_q), .out_wave(out_wave),
    .count_now(count_now)
  );
endmodule

// File: rtl/icc_counter_channel_chk.sv
module icc_counter_channel_chk
  import icc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             load_strobe,
  input logic [CNT_W-1:0] load_value,
  input logic             gate,
  input logic             out_wave,
  input logic [CNT_W-1:0] count_now,
  input icc_mode_e        mode_q,
  input logic [CNT_W-1:0] reload_q
);
  logic gate_prev;
  logic rise_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_prev <= 1'b0;
    else        gate_prev <= gate;
  end
  assign rise_seen = gate && !gate_prev;

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> count_now == $past(load_value));

  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !load_strobe && !rise_seen) |=> ($stable(count_now) && $stable(out_wave)));

  assert_term_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TERM && out_wave && !load_strobe) |=> out_wave);

  assert_rate_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && out_wave) |-> count_now == reload_q);

  assert_strobe_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_SWSTROBE || mode_q == MD_HWSTROBE) && out_wave) |-> count_now == '0);

  assert_retrig_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_ONESHOT || mode_q == MD_RATE || mode_q == MD_SQUARE ||
      mode_q == MD_HWSTROBE) && rise_seen && !load_strobe) |=> count_now == reload_q);

  assert_gate_pause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == MD_TERM || mode_q == MD_RATE || mode_q == MD_SQUARE ||
      mode_q == MD_SWSTROBE) && !gate && !load_strobe) |=> $stable(count_now));
endmodule

bind icc_counter_channel icc_counter_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en), .load_strobe(load_strobe),
  .load_value(load_value), .gate(gate), .out_wave(out_wave),
  .count_now(count_now), .mode_q(mode_q), .reload_q(reload_q)
);

// File: tb/icc_counter_channel_tb.sv
module icc_counter_channel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic        load_strobe;
  logic [15:0] load_value;
  logic [2:0]  mode_sel;
  logic        gate;
  logic        out_wave;
  logic [15:0] count_now;

  int checks = 0;
  int errors = 0;

  icc_counter_channel #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .load_strobe(load_strobe),
    .load_value(load_value), .mode_sel(mode_sel), .gate(gate),
    .out_wave(out_wave), .count_now(count_now)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input logic [15:0] exp_c, input logic exp_o);
    checks++;
    if (count_now !== exp_c || out_wave !== exp_o) begin
      errors++;
      $display("FAIL %s: actual count=%h out=%b, expected count=%h out=%b",
               tag, count_now, out_wave, exp_c, exp_o);
    end
  endtask

  task automatic do_load(input logic [15:0] v, input logic [2:0] m);
    @(negedge clk);
    load_strobe = 1'b1;
    load_value  = v;
    mode_sel    = m;
    @(negedge clk);
    load_strobe = 1'b0;
  endtask

  task automatic advance(input int n);
    if (n > 0) begin
      cnt_en = 1'b1;
      repeat (n) @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R12 reset state", 16'h0000, 1'b1);
  endtask

  task automatic t_mode0;
    do_load(16'd5, 3'd0);
    check("R2 load mode0", 16'd5, 1'b0);
    advance(4);
    check("R4 mode0 before terminal", 16'd1, 1'b0);
    repeat (3) @(negedge clk);
    check("R3 no tick holds", 16'd1, 1'b0);
    gate = 1'b0;
    advance(3);
    check("R10 mode0 gate low pauses", 16'd1, 1'b0);
    gate = 1'b1;
    @(negedge clk);
    check("R9 mode0 ignores gate rise", 16'd1, 1'b0);
    advance(1);
    check("R4 mode0 reaches terminal", 16'd0, 1'b1);
    advance(3);
    check("R4 mode0 stays high and wraps", 16'hFFFD, 1'b1);
  endtask

  task automatic t_mode1;
    do_load(16'd3, 3'd1);
    check("R5 mode1 after load", 16'd3, 1'b1);
    advance(3);
    check("R5 mode1 expired", 16'd0, 1'b0);
    gate = 1'b0;
    advance(2);
    check("R10 mode1 not paused", 16'hFFFE, 1'b0);
    gate = 1'b1;
    @(negedge clk);
    check("R9 mode1 retrigger", 16'd3, 1'b1);
  endtask

  task automatic t_mode2;
    do_load(16'd4, 3'd2);
    check("R6 mode2 after load", 16'd4, 1'b0);
    advance(3);
    check("R6 mode2 mid period", 16'd1, 1'b0);
    advance(1);
    check("R6 mode2 pulse", 16'd4, 1'b1);
    advance(1);
    check("R6 mode2 pulse ends", 16'd3, 1'b0);
  endtask

  task automatic t_mode3;
    do_load(16'd5, 3'd3);
    check("R7 mode3 after load", 16'd5, 1'b1);
    advance(1);
    check("R7 mode3 p1", 16'd3, 1'b1);
    gate = 1'b0;
    advance(3);
    check("R10 mode3 gate low pauses", 16'd3, 1'b1);
    gate = 1'b1;
    @(negedge clk);
    check("R9 mode3 retrigger", 16'd5, 1'b1);
    advance(2);
    check("R7 mode3 p2", 16'd1, 1'b1);
    advance(1);
    check("R7 mode3 p3 low half", 16'd4, 1'b0);
    advance(1);
    check("R7 mode3 p4", 16'd2, 1'b0);
    advance(1);
    check("R7 mode3 new period", 16'd5, 1'b1);
  endtask

  task automatic t_mode4;
    do_load(16'd2, 3'd4);
    check("R8 mode4 after load", 16'd2, 1'b0);
    advance(2);
    check("R8 mode4 strobe", 16'd0, 1'b1);
    advance(1);
    check("R8 mode4 strobe one count", 16'hFFFF, 1'b0);
  endtask

  task automatic t_mode5;
    do_load(16'd2, 3'd5);
    check("R8 mode5 after load", 16'd2, 1'b0);
    gate = 1'b0;
    advance(1);
    check("R10 mode5 not paused", 16'd1, 1'b0);
    advance(1);
    check("R8 mode5 strobe", 16'd0, 1'b1);
    gate = 1'b1;
    @(negedge clk);
    check("R9 mode5 retrigger", 16'd2, 1'b0);
  endtask

  task automatic t_alias;
    do_load(16'd4, 3'd6);
    advance(4);
    check("R11 code6 as rate", 16'd4, 1'b1);
    do_load(16'd5, 3'd7);
    advance(3);
    check("R11 code7 as square", 16'd4, 1'b0);
  endtask

  task automatic t_zero;
    do_load(16'd0, 3'd0);
    check("R1 zero load readback", 16'd0, 1'b0);
    advance(1);
    check("R1 zero first tick", 16'hFFFF, 1'b0);
    do_load(16'd0, 3'd3);
    advance(32767);
    check("R1 square 65536 high half", 16'd2, 1'b1);
    advance(1);
    check("R1 square 65536 low half", 16'd0, 1'b0);
    do_load(16'd0, 3'd2);
    advance(65535);
    check("R1 rate 65536 before pulse", 16'd1, 1'b0);
    advance(1);
    check("R1 rate 65536 pulse", 16'd0, 1'b1);
  endtask

  initial begin
    rst_n       = 1'b0;
    cnt_en      = 1'b0;
    load_strobe = 1'b0;
    load_value  = '0;
    mode_sel    = '0;
    gate        = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_alias();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule